// File: doc/BRIEF.md
# Paced DMA Channel Transfer Engine

This block is one DMA channel. It copies a run of elements from a source region to a destination region through a single memory-style bus master port. Every element is a read followed by a write of the same data. A transfer is set up by presenting a configuration on the `cfg_*` inputs and pulsing `go`. The configuration holds both start addresses, a 24-bit cycle count, one 3-bit address step code per side, the element width, a burst flag, a bus-select bit per side and a 4-bit pacing-line select per side. The channel latches the configuration and then runs on its own. It stops when the count is used up, when a bus access returns an error, or when `halt` asks it to stop.

A cycle is one beat (a read and a write) in single mode and four beats in burst mode. A side whose pacing select is non-zero waits for its request line before each cycle starts. When that cycle's last write completes, the channel pulses the matching grant line for one clock. The `remaining` output always shows how many cycles are still to run. The finish and error flags hold until their clear inputs are pulsed. Each flag drives `irq` only while its enable input is high.

The controller is a five-state machine:
- IDLE: no transfer is active.
- WAIT: waits for the pacing request lines.
- RD: the source read is in progress.
- WR: the destination write is in progress.
- END: the close of a cycle.

Transitions:
- IDLE→WAIT on `go` with a non-zero count.
- IDLE→IDLE on `go` with a zero count. This sets the finish flag.
- WAIT→RD when both sides are ready.
- WAIT→IDLE on a stop request.
- RD→WR on a clean read acknowledge.
- RD→IDLE on a read error.
- WR→RD on a clean write that is not the last beat of the cycle.
- WR→END on the last beat of the cycle.
- WR→IDLE on a write error, or on a stop request between beats.
- END→IDLE when the count reaches zero. This sets the finish flag.
- END→IDLE on a stop request.
- END→WAIT otherwise.

Top module: `dma_xfer_chan`

## Requirements
- R1: After reset the channel is idle: `busy`, `m_req`, `done_flag`, `err_flag`, `irq` and `remaining` are all 0.
- R2: Each side's address moves by a signed amount after every beat on that side. The 3-bit step code maps as follows: 000 and 100 give 0; 001 gives +1, 010 gives +2, 011 gives +4; 101 gives -1, 110 gives -2, 111 gives -4 bytes.
- R3: With `cfg_burst`=0 a cycle is one beat. With `cfg_burst`=1 a cycle is four beats, so the address change per cycle is four times the step. A completed transfer makes exactly 2×cycles×beats bus accesses.
- R4: Each beat is a read of the source address followed by a write of the read data to the destination address. `m_req` and `m_we` are held until `m_ack`. `m_size` carries the width code (00 word, 01 halfword, 10 byte). `m_sys` carries the bus-select bit of the side being accessed (0 peripheral bus, 1 system bus).
- R5: `remaining` loads the cycle count at `go` and drops by exactly one as each cycle's last write completes.
- R6: A pacing select of 0 means the side runs free. A select k in 1..15 makes the channel wait, before each cycle's first read, until `line_req[k-1]` is high. When both sides are paced, both lines must be high.
- R7: When a cycle's last write completes, `line_gnt[k-1]` pulses for exactly one clock for each paced side whose select is k. Unpaced sides produce no grant.
- R8: After the last cycle, `done_flag` sets and `busy` clears.
- R9: `go` with a cycle count of 0 sets `done_flag` at the next clock and makes no bus request.
- R10: An access acknowledged with `m_err` sets `err_flag`, clears `busy` and stops all further requests. It does not set `done_flag`.
- R11: `halt` during a transfer stops the channel at the next beat boundary, after a completed write. It does not set `done_flag`.
- R12: `irq` = (`done_flag` and `done_ie`) or (`err_flag` and `err_ie`). The flags stay set until `clr_done` or `clr_err` is pulsed.
- R13: `go` while the channel is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Latch configuration and start |
| halt | input | 1 | Stop at the next beat boundary |
| clr_done | input | 1 | Clear finish flag |
| clr_err | input | 1 | Clear error flag |
| done_ie | input | 1 | Finish interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| cfg_src_addr | input | 32 | Source start address |
| cfg_dst_addr | input | 32 | Destination start address |
| cfg_cycles | input | 24 | Cycle count |
| cfg_src_step | input | 3 | Source step code |
| cfg_dst_step | input | 3 | Destination step code |
| cfg_width | input | 2 | Element width code |
| cfg_burst | input | 1 | Four beats per cycle |
| cfg_src_sys | input | 1 | Source bus select |
| cfg_dst_sys | input | 1 | Destination bus select |
| cfg_src_line | input | 4 | Source pacing line (0 = none) |
| cfg_dst_line | input | 4 | Destination pacing line (0 = none) |
| line_req | input | 15 | Peripheral request lines |
| line_gnt | output | 15 | Peripheral grant pulses |
| m_req | output | 1 | Bus access request |
| m_we | output | 1 | Access is a write |
| m_addr | output | 32 | Access address |
| m_size | output | 2 | Access width code |
| m_sys | output | 1 | Access bus select |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data |
| m_ack | input | 1 | Access complete |
| m_err | input | 1 | Access failed (valid with m_ack) |
| busy | output | 1 | Transfer active |
| remaining | output | 24 | Cycles still to run |
| done_flag | output | 1 | Finish status |
| err_flag | output | 1 | Error status |
| irq | output | 1 | Interrupt |

## Verification
The in-RTL properties check the following on every cycle:
- a pending request keeps its address and direction until acknowledged;
- `remaining` only ever steps down by one;
- grant pulses never last more than one clock;
- the finish and error flags only rise with the channel idle, and never together;
- `irq` is never high without a flag.

The bench scenarios show what a single-cycle property cannot:
- the exact address sequence for every step code, in single and burst mode;
- the data moving from source to destination;
- the channel holding off while either pacing line is low;
- the zero-count shortcut;
- where an error or a halt leaves the count and the access log.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int LINE_W = 4;
    localparam int STEP_W = 3;
    localparam int WID_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RD,
        ST_WR,
        ST_END
    } chan_state_e;

    typedef struct packed {
        logic [STEP_W-1:0] src_step;
        logic [STEP_W-1:0] dst_step;
        logic [WID_W-1:0]  width;
        logic              burst;
        logic              src_sys;
        logic              dst_sys;
        logic [LINE_W-1:0] src_line;
        logic [LINE_W-1:0] dst_line;
    } chan_cfg_t;

    // Signed byte offset applied after each beat for a step code.
    function automatic logic signed [3:0] step_delta(input logic [STEP_W-1:0] code);
        logic signed [3:0] d;
        unique case (code)
            3'b001:  d = 4'sd1;
            3'b010:  d = 4'sd2;
            3'b011:  d = 4'sd4;
            3'b101:  d = -4'sd1;
            3'b110:  d = -4'sd2;
            3'b111:  d = -4'sd4;
            default: d = 4'sd0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [AW-1:0]     base,
    input  logic              adv,
    input  logic [STEP_W-1:0] code,
    output logic [AW-1:0]     addr
);

    logic signed [3:0] delta;
    logic [AW-1:0]     inc;

    always_comb begin
        delta = step_delta(code);
        inc   = {{(AW-4){delta[3]}}, delta};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= base;
        end else if (adv) begin
            addr <= addr + inc;
        end
    end

    // R2: a fixed-address code leaves the address untouched across a beat
    p_fixed_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && (code == 3'b000 || code == 3'b100)) |=> $stable(addr));

endmodule

// File: rtl/dma_pace.sv
module dma_pace
    import dma_chan_pkg::*;
#(
    parameter int NLINES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] sel,
    input  logic [NLINES-1:0] line_req,
    input  logic              fire,
    output logic              ready,
    output logic [NLINES-1:0] gnt
);

    logic [NLINES-1:0] hit;

    generate
        for (genvar k = 0; k < NLINES; k++) begin : g_line
            assign hit[k] = (sel == LINE_W'(k + 1)) && line_req[k];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    gnt[k] <= 1'b0;
                end else begin
                    gnt[k] <= fire && (sel == LINE_W'(k + 1));
                end
            end
        end
    endgenerate

    assign ready = (sel == '0) || (|hit);

    // R7: a grant never stays high for two clocks
    p_gnt_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> !(|gnt));

    // R7: grants only appear for a paced side
    p_gnt_paced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> $onehot(gnt));

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
#(
    parameter int CW          = 24,
    parameter int DW          = 32,
    parameter int BURST_BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          halt,
    input  logic          clr_done,
    input  logic          clr_err,
    input  logic [CW-1:0] cyc_in,
    input  chan_cfg_t     cfg_in,
    input  logic          src_rdy,
    input  logic          dst_rdy,
    input  logic          m_ack,
    input  logic          m_err,
    input  logic [DW-1:0] m_rdata,
    output chan_cfg_t     cfg,
    output logic          load,
    output logic          adv_src,
    output logic          adv_dst,
    output logic          fire,
    output logic          m_req,
    output logic          m_we,
    output logic [DW-1:0] wdata,
    output logic [CW-1:0] remaining,
    output logic          done_flag,
    output logic          err_flag,
    output logic          busy
);

    localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BURST = BEAT_W'(BURST_BEATS - 1);

    chan_state_e       state, nxt;
    logic [BEAT_W-1:0] beat;
    logic              stop_pend;
    logic              last_beat;
    logic              acc_ok, acc_bad;
    logic              stop_now;

    assign last_beat = (beat == (cfg.burst ? LAST_BURST : '0));
    assign acc_ok    = m_ack && !m_err;
    assign acc_bad   = m_ack && m_err;
    assign stop_now  = stop_pend || halt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (go && (cyc_in != '0)) nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (stop_now)                nxt = ST_IDLE;
                else if (src_rdy && dst_rdy) nxt = ST_RD;
            end
            ST_RD: begin
                if (acc_bad)     nxt = ST_IDLE;
                else if (acc_ok) nxt = ST_WR;
            end
            ST_WR: begin
                if (acc_bad)        nxt = ST_IDLE;
                else if (acc_ok) begin
                    if (last_beat)     nxt = ST_END;
                    else if (stop_now) nxt = ST_IDLE;
                    else               nxt = ST_RD;
                end
            end
            ST_END: begin
                if (remaining == '0 || stop_now) nxt = ST_IDLE;
                else                             nxt = ST_WAIT;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        m_req   = (state == ST_RD) || (state == ST_WR);
        m_we    = (state == ST_WR);
        busy    = (state != ST_IDLE);
        load    = (state == ST_IDLE) && go;
        adv_src = (state == ST_RD) && acc_ok;
        adv_dst = (state == ST_WR) && acc_ok;
        fire    = (state == ST_WR) && acc_ok && last_beat;
    end

    // Datapath and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg       <= '0;
            remaining <= '0;
            beat      <= '0;
            stop_pend <= 1'b0;
            wdata     <= '0;
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            if (clr_done) done_flag <= 1'b0;
            if (clr_err)  err_flag  <= 1'b0;
            if (halt && state != ST_IDLE) stop_pend <= 1'b1;

            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        cfg       <= cfg_in;
                        remaining <= cyc_in;
                        beat      <= '0;
                        stop_pend <= 1'b0;
                        if (cyc_in == '0) done_flag <= 1'b1;
                    end
                end
                ST_WAIT: ;
                ST_RD: begin
                    if (acc_ok)  wdata    <= m_rdata;
                    if (acc_bad) err_flag <= 1'b1;
                end
                ST_WR: begin
                    if (acc_bad) err_flag <= 1'b1;
                    if (acc_ok) begin
                        if (last_beat) begin
                            beat      <= '0;
                            remaining <= remaining - CW'(1);
                        end else begin
                            beat <= beat + BEAT_W'(1);
                        end
                    end
                end
                ST_END: begin
                    if (remaining == '0) done_flag <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R4: a pending access keeps its direction until acknowledged
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_we)));

    // R5: the count only ever drops by one while a transfer runs
    p_remain_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && remaining != $past(remaining))
            |-> (remaining == $past(remaining) - CW'(1)));

    // R8: the finish flag rises only with the channel idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> !busy);

    // R10: an error stops requests and never coincides with finish
    p_err_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (!busy && !m_req && !$rose(done_flag)));

    // R1: no access is requested while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_req);

endmodule

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan
    import dma_chan_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int CW          = 24,
    parameter int NLINES      = 15,
    parameter int BURST_BEATS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              halt,
    input  logic              clr_done,
    input  logic              clr_err,
    input  logic              done_ie,
    input  logic              err_ie,
    input  logic [AW-1:0]     cfg_src_addr,
    input  logic [AW-1:0]     cfg_dst_addr,
    input  logic [CW-1:0]     cfg_cycles,
    input  logic [2:0]        cfg_src_step,
    input  logic [2:0]        cfg_dst_step,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_burst,
    input  logic              cfg_src_sys,
    input  logic              cfg_dst_sys,
    input  logic [3:0]        cfg_src_line,
    input  logic [3:0]        cfg_dst_line,
    input  logic [NLINES-1:0] line_req,
    output logic [NLINES-1:0] line_gnt,
    output logic              m_req,
    output logic              m_we,
    output logic [AW-1:0]     m_addr,
    output logic [1:0]        m_size,
    output logic              m_sys,
    output logic [DW-1:0]     m_wdata,
    input  logic [DW-1:0]     m_rdata,
    input  logic              m_ack,
    input  logic              m_err,
    output logic              busy,
    output logic [CW-1:0]     remaining,
    output logic              done_flag,
    output logic              err_flag,
    output logic              irq
);

    chan_cfg_t         cfg_in, cfg;
    logic              load, adv_src, adv_dst, fire;
    logic              src_rdy, dst_rdy;
    logic [AW-1:0]     src_addr, dst_addr;
    logic [NLINES-1:0] gnt_src, gnt_dst;

    always_comb begin
        cfg_in.src_step = cfg_src_step;
        cfg_in.dst_step = cfg_dst_step;
        cfg_in.width    = cfg_width;
        cfg_in.burst    = cfg_burst;
        cfg_in.src_sys  = cfg_src_sys;
        cfg_in.dst_sys  = cfg_dst_sys;
        cfg_in.src_line = cfg_src_line;
        cfg_in.dst_line = cfg_dst_line;
    end

    dma_chan_fsm #(.CW(CW), .DW(DW), .BURST_BEATS(BURST_BEATS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .halt      (halt),
        .clr_done  (clr_done),
        .clr_err   (clr_err),
        .cyc_in    (cfg_cycles),
        .cfg_in    (cfg_in),
        .src_rdy   (src_rdy),
        .dst_rdy   (dst_rdy),
        .m_ack     (m_ack),
        .m_err     (m_err),
        .m_rdata   (m_rdata),
        .cfg       (cfg),
        .load      (load),
        .adv_src   (adv_src),
        .adv_dst   (adv_dst),
        .fire      (fire),
        .m_req     (m_req),
        .m_we      (m_we),
        .wdata     (m_wdata),
        .remaining (remaining),
        .done_flag (done_flag),
        .err_flag  (err_flag),
        .busy      (busy)
    );

    dma_addr_step #(.AW(AW)) u_src_addr (
        .clk (clk), .rst_n (rst_n), .load (load), .base (cfg_src_addr),
        .adv (adv_src), .code (cfg.src_step), .addr (src_addr)
    );

    dma_addr_step #(.AW(AW)) u_dst_addr (
        .clk (clk), .rst_n (rst_n), .load (load), .base (cfg_dst_addr),
        .adv (adv_dst), .code (cfg.dst_step), .addr (dst_addr)
    );

    dma_pace #(.NLINES(NLINES)) u_src_pace (
        .clk (clk), .rst_n (rst_n), .sel (cfg.src_line), .line_req (line_req),
        .fire (fire), .ready (src_rdy), .gnt (gnt_src)
    );

    dma_pace #(.NLINES(NLINES)) u_dst_pace (
        .clk (clk), .rst_n (rst_n), .sel (cfg.dst_line), .line_req (line_req),
        .fire (fire), .ready (dst_rdy), .gnt (gnt_dst)
    );

    assign line_gnt = gnt_src | gnt_dst;
    assign m_addr   = m_we ? dst_addr : src_addr;
    assign m_size   = cfg.width;
    assign m_sys    = m_we ? cfg.dst_sys : cfg.src_sys;
    assign irq      = (done_flag && done_ie) || (err_flag && err_ie);

    // R12: an interrupt always has a flag behind it
    p_irq_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_flag || err_flag));

    // R4: the access address holds while waiting for acknowledge
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> $stable(m_addr));

endmodule

// File: tb/sim_dma_xfer_chan.sv
module sim_dma_xfer_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 0, halt = 0, clr_done = 0, clr_err = 0, done_ie = 0, err_ie = 0;
    logic [31:0] cfg_src_addr = 0, cfg_dst_addr = 0;
    logic [23:0] cfg_cycles = 0;
    logic [2:0]  cfg_src_step = 0, cfg_dst_step = 0;
    logic [1:0]  cfg_width = 0;
    logic        cfg_burst = 0, cfg_src_sys = 0, cfg_dst_sys = 0;
    logic [3:0]  cfg_src_line = 0, cfg_dst_line = 0;
    logic [14:0] line_req = 0;
    logic [14:0] line_gnt;
    logic        m_req, m_we, m_sys;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [1:0]  m_size;
    logic        m_ack = 1'b0;
    logic        m_err;
    logic        busy, done_flag, err_flag, irq;
    logic [23:0] remaining;

    logic        err_arm = 1'b0;
    logic [31:0] err_addr = 0;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dma_xfer_chan u0 (.*);

    // Bus slave model: one-cycle latency, data derived from address
    always @(negedge clk) m_ack <= m_req && !m_ack;
    assign m_rdata = {~m_addr[15:0], m_addr[15:0]};
    assign m_err   = m_ack && err_arm && (m_addr == err_addr);

    // Access log and grant counters
    logic        lg_we   [512];
    logic [31:0] lg_addr [512];
    logic [31:0] lg_data [512];
    logic [1:0]  lg_size [512];
    logic        lg_sys  [512];
    int          lg_n = 0;
    int          gnt_cnt [15];
    logic [14:0] gnt_prev = 0;
    logic        gnt_dbl = 0;

    initial for (int k = 0; k < 15; k++) gnt_cnt[k] = 0;

    always @(posedge clk) begin
        if (m_req && m_ack && !m_err && lg_n < 512) begin
            lg_we[lg_n]   <= m_we;
            lg_addr[lg_n] <= m_addr;
            lg_data[lg_n] <= m_wdata;
            lg_size[lg_n] <= m_size;
            lg_sys[lg_n]  <= m_sys;
            lg_n          <= lg_n + 1;
        end
        for (int k = 0; k < 15; k++) if (line_gnt[k]) gnt_cnt[k] <= gnt_cnt[k] + 1;
        if ((line_gnt & gnt_prev) != 0) gnt_dbl <= 1'b1;
        gnt_prev <= line_gnt;
    end

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [7:0]  cyc;
        logic [2:0]  ss;
        logic [2:0]  ds;
        logic [1:0]  w;
        logic        b;
        logic        ssys;
        logic        dsys;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{32'h1000, 32'h2000, 8'd3, 3'b001, 3'b001, 2'b10, 1'b0, 1'b0, 1'b1},
        '{32'h1100, 32'h2100, 8'd2, 3'b011, 3'b000, 2'b00, 1'b1, 1'b1, 1'b0},
        '{32'h1200, 32'h2200, 8'd2, 3'b111, 3'b110, 2'b01, 1'b1, 1'b1, 1'b1},
        '{32'h1300, 32'h2300, 8'd4, 3'b101, 3'b010, 2'b10, 1'b0, 1'b0, 1'b0},
        '{32'h1400, 32'h2400, 8'd1, 3'b000, 3'b011, 2'b00, 1'b1, 1'b0, 1'b1},
        '{32'h1500, 32'h2500, 8'd2, 3'b100, 3'b111, 2'b01, 1'b0, 1'b1, 1'b0}
    };

    function automatic int stride(input logic [2:0] c);
        case (c)
            3'b001: return 1;
            3'b010: return 2;
            3'b011: return 4;
            3'b101: return -1;
            3'b110: return -2;
            3'b111: return -4;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 3000 && busy; n++) @(negedge clk);
    endtask

    task automatic pulse_go();
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
    endtask

    task automatic set_cfg(input vec_t v);
        cfg_src_addr = v.src; cfg_dst_addr = v.dst; cfg_cycles = 24'(v.cyc);
        cfg_src_step = v.ss;  cfg_dst_step = v.ds;  cfg_width = v.w;
        cfg_burst = v.b; cfg_src_sys = v.ssys; cfg_dst_sys = v.dsys;
    endtask

    task automatic clear_flags();
        @(negedge clk) begin clr_done = 1'b1; clr_err = 1'b1; end
        @(negedge clk) begin clr_done = 1'b0; clr_err = 1'b0; end
    endtask

    task automatic run_vec(input vec_t v);
        int start, beats, n, bad_addr, bad_data;
        logic [31:0] es, ed;
        set_cfg(v);
        cfg_src_line = 0; cfg_dst_line = 0;
        start = lg_n;
        pulse_go();
        wait_idle();
        @(negedge clk);
        beats = v.b ? 4 : 1;
        n = int'(v.cyc) * beats;
        chk(lg_n - start == 2 * n, "R3 access count", 32'(lg_n - start), 32'(2 * n));
        bad_addr = 0; bad_data = 0;
        for (int j = 0; j < n; j++) begin
            es = v.src + 32'(j * stride(v.ss));
            ed = v.dst + 32'(j * stride(v.ds));
            if (lg_we[start + 2*j] !== 1'b0 || lg_addr[start + 2*j] !== es) bad_addr++;
            if (lg_we[start + 2*j + 1] !== 1'b1 || lg_addr[start + 2*j + 1] !== ed) bad_addr++;
            if (lg_data[start + 2*j + 1] !== {~es[15:0], es[15:0]}) bad_data++;
            if (lg_size[start + 2*j] !== v.w || lg_size[start + 2*j + 1] !== v.w) bad_data++;
            if (lg_sys[start + 2*j] !== v.ssys || lg_sys[start + 2*j + 1] !== v.dsys) bad_data++;
        end
        chk(bad_addr == 0, "R2 address sequence", 32'(bad_addr), 0);
        chk(bad_data == 0, "R4 data/size/bus-select", 32'(bad_data), 0);
        chk(done_flag && !busy, "R8 finish", {busy, done_flag}, 32'b01);
        chk(remaining == 0, "R5 count at end", 32'(remaining), 0);
        chk(!irq, "R12 irq masked", 32'(irq), 0);
        clear_flags();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int start;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !m_req && !done_flag && !err_flag && !irq && remaining == 0,
            "R1 reset state", {busy, m_req, done_flag, err_flag, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R6/R7/R5/R13: paced transfer on lines 5 (source) and 9 (destination)
        set_cfg('{32'h3000, 32'h4000, 8'd3, 3'b001, 3'b001, 2'b00, 1'b0, 1'b0, 1'b0});
        cfg_src_line = 4'd5; cfg_dst_line = 4'd9; done_ie = 1'b1;
        start = lg_n;
        pulse_go();
        repeat (10) @(negedge clk);
        chk(lg_n == start && busy, "R6 wait with no request", 32'(lg_n - start), 0);
        cfg_cycles = 24'd7;
        pulse_go();
        @(negedge clk);
        chk(remaining == 3, "R13 go while busy ignored", 32'(remaining), 3);
        line_req[4] = 1'b1;
        repeat (10) @(negedge clk);
        chk(lg_n == start, "R6 both lines needed", 32'(lg_n - start), 0);
        line_req[8] = 1'b1;
        for (int n = 0; n < 100 && !line_gnt[4]; n++) @(negedge clk);
        line_req = '0;
        chk(line_gnt[4] && line_gnt[8], "R7 grant on both paced lines", 32'(line_gnt), 32'h110);
        chk(remaining == 2, "R5 count after one cycle", 32'(remaining), 2);
        repeat (10) @(negedge clk);
        chk(lg_n - start == 2, "R6 paused between cycles", 32'(lg_n - start), 2);
        line_req[4] = 1'b1; line_req[8] = 1'b1;
        wait_idle();
        @(negedge clk);
        line_req = '0;
        chk(gnt_cnt[4] == 3 && gnt_cnt[8] == 3, "R7 one grant per cycle", 32'(gnt_cnt[4]), 3);
        chk(!gnt_dbl, "R7 grant one clock wide", 32'(gnt_dbl), 0);
        chk(done_flag && irq, "R12 finish interrupt", {done_flag, irq}, 32'b11);
        done_ie = 1'b0;
        @(negedge clk);
        chk(!irq && done_flag, "R12 enable masks irq, flag holds", {done_flag, irq}, 32'b10);
        clear_flags();
        chk(!done_flag, "R12 clear finish", 32'(done_flag), 0);
        cfg_src_line = 0; cfg_dst_line = 0;

        // R9 zero count
        cfg_cycles = 0;
        start = lg_n;
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
        chk(done_flag && !busy, "R9 zero count finishes at once", {busy, done_flag}, 32'b01);
        repeat (5) @(negedge clk);
        chk(lg_n == start, "R9 no bus access", 32'(lg_n - start), 0);
        clear_flags();

        // R10 bus error on the second read
        set_cfg('{32'h5000, 32'h6000, 8'd4, 3'b011, 3'b011, 2'b00, 1'b0, 1'b0, 1'b0});
        err_arm = 1'b1; err_addr = 32'h5004; err_ie = 1'b1;
        start = lg_n;
        pulse_go();
        wait_idle();
        repeat (5) @(negedge clk);
        chk(err_flag && !done_flag && !busy, "R10 error stops channel", {busy, done_flag, err_flag}, 32'b001);
        chk(lg_n - start == 2, "R10 no access after error", 32'(lg_n - start), 2);
        chk(remaining == 3, "R10 count left at error", 32'(remaining), 3);
        chk(irq, "R12 error interrupt", 32'(irq), 1);
        err_arm = 1'b0; err_ie = 1'b0;
        clear_flags();
        chk(!err_flag, "R12 clear error", 32'(err_flag), 0);

        // R11 halt mid-transfer
        set_cfg('{32'h7000, 32'h8000, 8'd5, 3'b001, 3'b001, 2'b00, 1'b1, 1'b0, 1'b0});
        start = lg_n;
        pulse_go();
        repeat (7) @(negedge clk);
        halt = 1'b1;
        @(negedge clk) halt = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        chk(!busy && !done_flag, "R11 halt without finish", {busy, done_flag}, 0);
        chk(((lg_n - start) % 2 == 0) && (lg_n - start) > 0 && (lg_n - start) < 40,
            "R11 stop on beat boundary", 32'(lg_n - start), 0);
        chk(lg_we[lg_n - 1] == 1'b1, "R11 last access is a write", 32'(lg_we[lg_n - 1]), 1);
        chk(remaining != 0, "R11 cycles left after halt", 32'(remaining), 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule